// File: doc/BRIEF.md
# Far-End Link Status Register with Interrupt Mask

This block holds an 8-bit view of the link condition reported by a device at the far end of a serial link. Four level inputs carry that condition: loss of signal on the remote device's receive port A, loss of signal on its receive port B, which of its two receive ports is active, and whether its descrambler has lost lock. The block latches the alarms so that software sees them, tracks the active-port selection as a live value, and sets a sticky change flag whenever any of the four reported values moves.

Software reads the status through a read strobe. Alarm bits and the change flag clear on that read. The active-port bit never clears on a read. An 8-bit mask register picks which status bits drive a single interrupt line. While the local receiver reports loss of signal, the status register is held at its reset pattern. The reported values cannot be trusted in that state, so no change is flagged for them.

Top module: `remote_status_reg`

## Requirements
- R1: During synchronous reset `status_q` becomes 0x0D, `enable_q` becomes 0x00 and `irq` becomes 0.
- R2: The status fields are: bit 4 is the change flag, bit 3 is remote loss of signal on port A, bit 2 is remote loss of signal on port B, bit 1 is the active port (1 = port B), and bit 0 is descrambler out of lock (1 = out of lock). Bits 7..5 always read 0.
- R3: Bits 3, 2 and 0 are sticky. Each one sets at the clock edge where its input is 1 and holds until it is cleared.
- R4: Bit 1 follows `rem_act_b` with a one-cycle delay and is not affected by `rd_status`.
- R5: A cycle with `rd_status` high clears bits 4, 3, 2 and 0 at the next edge. If an input is still 1, its bit sets again at that same edge.
- R6: When a set condition and a read occur in the same cycle, the bit ends up set.
- R7: The change flag sets when the four inputs differ from their values one cycle earlier. Just after reset, those earlier values count as 1,1,0,1 (port A loss, port B loss, active port, out of lock).
- R8: A change is not flagged while `local_los` is high. The inputs are still tracked during that time, so a change that happens inside a loss-of-signal window is not flagged once the window ends.
- R9: While `local_los` is high, `status_q` is reloaded with 0x0D at every edge. `enable_q` is not changed by it.
- R10: `wr_enable` loads `wr_data[4:0]` into `enable_q[4:0]` at the next edge. `enable_q[7:5]` always read 0.
- R11: `irq` is registered. In cycle n+1 it equals the OR over bits 4..0 of (`status_q` AND `enable_q`) taken in cycle n.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| local_los | input | 1 | Local loss of signal; holds the status at its reset pattern |
| rem_los_a | input | 1 | Far end reports loss of signal on its port A |
| rem_los_b | input | 1 | Far end reports loss of signal on its port B |
| rem_act_b | input | 1 | Far end's active receive port is B |
| rem_oolock | input | 1 | Far end's descrambler is out of lock |
| rd_status | input | 1 | Status read strobe; clears the clear-on-read bits |
| wr_enable | input | 1 | Write strobe for the interrupt mask |
| wr_data | input | 8 | Write data for the interrupt mask |
| status_q | output | 8 | Status register |
| enable_q | output | 8 | Interrupt mask register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a change in the far-end inputs that happens while the local loss of signal is asserted. After such a change the status looks the same as after a quiet window: it shows 0x0D in both cases. The stimulus therefore moves the inputs inside the window, releases the window with the inputs held steady, and issues a read in that same cycle. A status of 0x00 shows that no stale change was flagged. The vector table also drives a read in the same cycle as new sets. This shows that the set wins, that a bit sets again while its input is still 1, and that the active-port bit survives the read.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int DW      = 8;
  localparam int NSRC    = 4;
  // positions within the status word
  localparam int B_OOL   = 0;
  localparam int B_ACT   = 1;
  localparam int B_LOSB  = 2;
  localparam int B_LOSA  = 3;
  localparam int B_CHG   = 4;
  localparam int NIMPL   = NSRC + 1;
  localparam logic [DW-1:0]   STAT_RST = 8'h0D;
  localparam logic [NSRC-1:0] SRC_RST  = STAT_RST[NSRC-1:0];
  localparam logic [NSRC-1:0] RO_MASK  = 4'b0010;
endpackage

// File: rtl/rsr_change_det.sv
module rsr_change_det #(
  parameter int N = 4,
  parameter logic [N-1:0] PREV_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [N-1:0] cur,
  output logic         changed
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= PREV_RST;
    else     prev_q <= cur;
  end

  always_comb changed = !hold && (cur != prev_q);
endmodule

// File: rtl/rsr_status_bits.sv
module rsr_status_bits #(
  parameter int DW = 8,
  parameter int N  = 4,
  parameter logic [N-1:0]  RO   = '0,
  parameter logic [DW-1:0] RSTV = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          force_rst,
  input  logic          clr,
  input  logic [N-1:0]  cond,
  input  logic          chg,
  output logic [DW-1:0] status
);
  localparam int CHG_POS = N;

  generate
    for (genvar i = 0; i < N; i++) begin : g_src
      if (RO[i]) begin : g_live
        always_ff @(posedge clk) begin
          if (rst || force_rst) status[i] <= RSTV[i];
          else                  status[i] <= cond[i];
        end
      end else begin : g_sticky
        always_ff @(posedge clk) begin
          if (rst || force_rst) status[i] <= RSTV[i];
          else                  status[i] <= cond[i] | (status[i] & ~clr);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst || force_rst) status[CHG_POS] <= RSTV[CHG_POS];
      else                  status[CHG_POS] <= chg | (status[CHG_POS] & ~clr);
    end

    for (genvar j = N + 1; j < DW; j++) begin : g_rsvd
      assign status[j] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/rsr_irq_gen.sv
module rsr_irq_gen #(
  parameter int DW    = 8,
  parameter int NIMPL = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] status,
  output logic [DW-1:0] enable,
  output logic          irq
);
  logic [NIMPL-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (wr) en_q <= wdata[NIMPL-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status[NIMPL-1:0] & en_q);
  end

  always_comb enable = {{(DW-NIMPL){1'b0}}, en_q};
endmodule

// File: rtl/remote_status_reg.sv
module remote_status_reg
  import rsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          local_los,
  input  logic          rem_los_a,
  input  logic          rem_los_b,
  input  logic          rem_act_b,
  input  logic          rem_oolock,
  input  logic          rd_status,
  input  logic          wr_enable,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] status_q,
  output logic [DW-1:0] enable_q,
  output logic          irq
);
  logic [NSRC-1:0] src;
  logic            chg;

  always_comb begin
    src         = '0;
    src[B_LOSA] = rem_los_a;
    src[B_LOSB] = rem_los_b;
    src[B_ACT]  = rem_act_b;
    src[B_OOL]  = rem_oolock;
  end

  rsr_change_det #(.N(NSRC), .PREV_RST(SRC_RST)) u_chg (
    .clk(clk), .rst(rst), .hold(local_los), .cur(src), .changed(chg)
  );

  rsr_status_bits #(.DW(DW), .N(NSRC), .RO(RO_MASK), .RSTV(STAT_RST)) u_bits (
    .clk(clk), .rst(rst), .force_rst(local_los), .clr(rd_status),
    .cond(src), .chg(chg), .status(status_q)
  );

  rsr_irq_gen #(.DW(DW), .NIMPL(NIMPL)) u_irq (
    .clk(clk), .rst(rst), .wr(wr_enable), .wdata(wr_data),
    .status(status_q), .enable(enable_q), .irq(irq)
  );
endmodule

// File: rtl/rsr_chk.sv
module rsr_chk (
  input logic       clk,
  input logic       rst,
  input logic       local_los,
  input logic       rem_los_a,
  input logic       rem_los_b,
  input logic       rem_act_b,
  input logic       rem_oolock,
  input logic       rd_status,
  input logic       wr_enable,
  input logic [7:0] wr_data,
  input logic [7:0] status_q,
  input logic [7:0] enable_q,
  input logic       irq
);
  // R9
  los_reload_chk: assert property (@(posedge clk) disable iff (rst)
    local_los |=> status_q == 8'h0D);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status_q[7:5] == 3'b000 && enable_q[7:5] == 3'b000);

  // R3
  los_a_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!local_los && rem_los_a) |=> status_q[3]);

  // R4
  act_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !local_los |=> status_q[1] == $past(rem_act_b));

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!local_los && rd_status && !rem_oolock) |=> !status_q[0]);

  // R10
  en_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_enable |=> enable_q == {3'b000, $past(wr_data[4:0])});

  // R11
  irq_reg_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == |($past(status_q[4:0] & enable_q[4:0])));
endmodule

bind remote_status_reg rsr_chk u_chk (
  .clk(clk), .rst(rst), .local_los(local_los), .rem_los_a(rem_los_a),
  .rem_los_b(rem_los_b), .rem_act_b(rem_act_b), .rem_oolock(rem_oolock),
  .rd_status(rd_status), .wr_enable(wr_enable), .wr_data(wr_data),
  .status_q(status_q), .enable_q(enable_q), .irq(irq)
);

// File: tb/tb_remote_status_reg.sv
`timescale 1ns/1ps
module tb_remote_status_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       local_los = 1'b0;
  logic       rem_los_a = 1'b1, rem_los_b = 1'b1, rem_act_b = 1'b0, rem_oolock = 1'b1;
  logic       rd_status = 1'b0, wr_enable = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status_q, enable_q;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  remote_status_reg dut (
    .clk(clk), .rst(rst), .local_los(local_los), .rem_los_a(rem_los_a),
    .rem_los_b(rem_los_b), .rem_act_b(rem_act_b), .rem_oolock(rem_oolock),
    .rd_status(rd_status), .wr_enable(wr_enable), .wr_data(wr_data),
    .status_q(status_q), .enable_q(enable_q), .irq(irq)
  );

  // entry: {local_los, rd, in[3:0] = losA,losB,actB,oolock, expected status}
  localparam int NV = 15;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b0, 4'b1101, 8'h0D},  // R3 steady
    {1'b0, 1'b0, 4'b0000, 8'h1D},  // R3 sticky, R7 change
    {1'b0, 1'b1, 4'b0000, 8'h00},  // R5 clear
    {1'b0, 1'b0, 4'b0010, 8'h12},  // R4 R7
    {1'b0, 1'b1, 4'b0010, 8'h02},  // R4 survives read
    {1'b0, 1'b1, 4'b0010, 8'h02},  // R4
    {1'b0, 1'b1, 4'b1000, 8'h18},  // R6 set wins
    {1'b0, 1'b1, 4'b1000, 8'h08},  // R5 re-set while asserted
    {1'b0, 1'b0, 4'b0000, 8'h18},  // R7
    {1'b0, 1'b1, 4'b0100, 8'h14},  // R6
    {1'b0, 1'b0, 4'b0001, 8'h15},  // R3 R7
    {1'b1, 1'b0, 4'b0011, 8'h0D},  // R9
    {1'b1, 1'b0, 4'b0000, 8'h0D},  // R9
    {1'b0, 1'b1, 4'b0000, 8'h00},  // R8 no stale change
    {1'b0, 1'b0, 4'b0000, 8'h00}   // R8
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic los, input logic rd, input logic [3:0] src);
    local_los = los; rd_status = rd;
    {rem_los_a, rem_los_b, rem_act_b, rem_oolock} = src;
    @(posedge clk); #1;
    rd_status = 1'b0; local_los = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {rem_los_a, rem_los_b, rem_act_b, rem_oolock} = 4'b1101;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
  endtask

  task automatic write_en(input logic [7:0] d, input logic [3:0] src);
    wr_enable = 1'b1; wr_data = d;
    step(1'b0, 1'b0, src);
    wr_enable = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 status", status_q, 8'h0D);
    chk("R1 enable", enable_q, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:8]);
      chk($sformatf("R2-table vec%0d (R3/R4/R5/R6/R7/R8/R9)", i), status_q, VEC[i][7:0]);
    end

    // R10 mask write, reserved bits read 0
    do_reset();
    write_en(8'hFF, 4'b1101);
    chk("R10 enable write", enable_q, 8'h1F);
    write_en(8'h01, 4'b1101);
    chk("R10 enable rewrite", enable_q, 8'h01);
    // R11 irq lags: previous mask 1F with status 0D gives 1
    chk("R11 irq from prior mask", {7'b0, irq}, 8'h01);
    write_en(8'h00, 4'b1101);
    step(1'b0, 1'b0, 4'b1101);
    chk("R11 irq masked off", {7'b0, irq}, 8'h00);

    // R11 active-port bit raises irq one cycle after it sets
    write_en(8'h02, 4'b1101);
    step(1'b0, 1'b0, 4'b1101);
    chk("R11 irq idle with bit1 low", {7'b0, irq}, 8'h00);
    step(1'b0, 1'b0, 4'b1111);
    chk("R4 bit1 set", status_q, 8'h1F);
    chk("R11 irq not yet", {7'b0, irq}, 8'h00);
    step(1'b0, 1'b0, 4'b1111);
    chk("R11 irq asserted", {7'b0, irq}, 8'h01);

    // R9 local loss keeps the mask
    step(1'b1, 1'b0, 4'b1111);
    chk("R9 status reload", status_q, 8'h0D);
    chk("R9 enable kept", enable_q, 8'h02);

    // R7 change seen against reset history
    do_reset();
    step(1'b0, 1'b0, 4'b1100);
    chk("R7 change after reset", status_q, 8'h1D);
    chk("R1 irq cleared by reset", {7'b0, irq}, 8'h00);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule